// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Address-Space Tags

This block translates a 32-bit virtual address into a 32-bit physical address in the same cycle the address is presented. It searches all 64 entries at once. Each entry pairs a 20-bit virtual page number and a 6-bit address-space tag with a 20-bit physical frame number. Each entry also carries four flags: valid, dirty (writable), non-cacheable and global. A global entry matches under any current address-space tag. A matching entry returns its frame joined to the 12-bit page offset, together with its cacheability. A lookup that finds no entry raises a miss. Refilling the buffer is left to software.

The three top address bits pick a segment. Two of the kernel segments map directly to physical memory without using the buffer: one is cached and one is uncached. The user segment and the upper kernel segment go through the buffer. Software loads entries through a write port. The slot comes either from an explicit index or from a free-running replacement counter that never selects the eight lowest slots. A probe port searches for a page number under the current tag and reports the slot it finds, or a fail flag. Two fault outputs report lookups that must not complete: one for a matching entry that is marked invalid, and one for a store to a page that is not marked dirty.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry holds all-zero fields (invalid, clean, not global), the replacement counter holds 63, probe_idx and probe_fail are 0, and while acc_en is 0 the outputs hit, miss, fault_invalid, fault_modify, uncached are 0 and pa is 0.
- R2: For a translated address (acc_va[31]=0, or acc_va[31:30]=2'b11) with a matching valid entry, hit is 1 in the same cycle, pa = {entry frame, acc_va[11:0]} and uncached equals the entry's non-cacheable flag.
- R3: An entry matches when its page number equals acc_va[31:12] and either its tag equals cur_asid or its global flag is set.
- R4: A translated address with no matching entry gives miss=1, hit=0, both faults 0, uncached=0 and pa=0. At most one of hit, miss, fault_invalid is 1 at any time.
- R5: acc_va[31:29]=3'b100 gives hit=1, uncached=0 and pa={3'b000, acc_va[28:0]}. acc_va[31:29]=3'b101 gives the same with uncached=1. Neither produces miss or a fault, whatever cur_asid and acc_store are.
- R6: A translated address whose matching entry has valid=0 gives fault_invalid=1 with hit=0, miss=0 and pa=0.
- R7: A store (acc_store=1) that hits an entry with dirty=0 raises fault_modify while hit stays 1. A store to a dirty entry, a load, or any access to a kernel physical segment raises no fault_modify.
- R8: When several entries match, the one at the lowest index supplies the lookup result and the probe result.
- R9: With wr_en=1 and wr_random=0, slot wr_index is overwritten at the clock edge. The new contents, and the loss of the old ones, are visible from the next cycle.
- R10: The replacement counter decreases by one on every clock edge and goes from 8 to 63. A write with wr_random=1 stores into the slot the counter holds before that edge. Slots 0 to 7 are never chosen.
- R11: A probe (probe_en=1) with probe_vpn under cur_asid updates the outputs at the next edge. probe_idx gets the matching slot and probe_fail=0, or probe_idx=0 and probe_fail=1 when nothing matches. Both hold while probe_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Lookup active |
| acc_va | input | 32 | Virtual address to translate |
| acc_store | input | 1 | Access is a store |
| cur_asid | input | 6 | Current address-space tag (lookup and probe) |
| wr_en | input | 1 | Load an entry |
| wr_random | input | 1 | Use replacement counter as slot |
| wr_index | input | 6 | Explicit slot |
| wr_vpn | input | 20 | Page number to load |
| wr_asid | input | 6 | Tag to load |
| wr_pfn | input | 20 | Frame to load |
| wr_nc | input | 1 | Non-cacheable flag |
| wr_dirty | input | 1 | Dirty (writable) flag |
| wr_valid | input | 1 | Valid flag |
| wr_global | input | 1 | Global flag |
| probe_en | input | 1 | Start a probe |
| probe_vpn | input | 20 | Page number to probe |
| pa | output | 32 | Physical address |
| hit | output | 1 | Translation succeeded |
| miss | output | 1 | No matching entry |
| uncached | output | 1 | Access is uncached |
| fault_invalid | output | 1 | Matching entry not valid |
| fault_modify | output | 1 | Store to a clean page |
| probe_idx | output | 6 | Slot found by the last probe |
| probe_fail | output | 1 | Last probe found nothing |

## Verification
Lookup results (pa, hit, miss, uncached and both faults) are combinational and due in the cycle the address is applied. The bench drives each address at a falling edge and samples it two nanoseconds later, well before the next rising edge. Writes and probes take effect at the first rising edge after they are driven. They are checked at the falling edge that follows, so exactly one register stage is counted. The slot for a random write is predicted from a count of rising edges since reset release, read at the falling edge where the write is issued.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VPN_W  = 20;
  localparam int OFF_W  = 12;
  localparam int ASID_W = 6;
  localparam int PFN_W  = 20;
  localparam int VA_W   = VPN_W + OFF_W;
  localparam int PA_W   = PFN_W + OFF_W;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PFN_W-1:0]  pfn;
    logic              nc;
    logic              dirty;
    logic              valid;
    logic              glob;
  } tlb_entry_t;

  typedef enum logic [1:0] {
    SEG_USER      = 2'd0,
    SEG_KCACHED   = 2'd1,
    SEG_KUNCACHED = 2'd2,
    SEG_KMAPPED   = 2'd3
  } seg_t;

  // Segment from the three top address bits
  function automatic seg_t seg_of(input logic [2:0] top);
    if (!top[2])      return SEG_USER;
    else if (top[1])  return SEG_KMAPPED;
    else if (top[0])  return SEG_KUNCACHED;
    else              return SEG_KCACHED;
  endfunction

  // Tag comparison: page number equal and tag equal unless global
  function automatic logic tag_match(input tlb_entry_t e,
                                     input logic [VPN_W-1:0] vpn,
                                     input logic [ASID_W-1:0] asid);
    return (e.vpn == vpn) && (e.glob || (e.asid == asid));
  endfunction
endpackage

// File: rtl/tlb_seg_decode.sv
module tlb_seg_decode
  import tlb_pkg::*;
(
  input  logic [2:0] va_top,
  output logic       mapped,
  output logic       phys_uncached
);
  seg_t seg;
  always_comb begin
    seg           = seg_of(va_top);
    mapped        = (seg == SEG_USER) || (seg == SEG_KMAPPED);
    phys_uncached = (seg == SEG_KUNCACHED);
  end
endmodule

// File: rtl/tlb_rand_idx.sv
module tlb_rand_idx #(
  parameter int NUM_ENTRIES = 64,
  parameter int LOW_BOUND   = 8,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_ENTRIES - 1);
  localparam logic [IDX_W-1:0] LOW = IDX_W'(LOW_BOUND);

  logic at_low;
  assign at_low = (idx == LOW);

  always_ff @(posedge clk) begin
    if (!rst_n)      idx <= TOP;
    else if (at_low) idx <= TOP;
    else             idx <= idx - 1'b1;
  end

  // R10: counter stays inside the replaceable window
  p_rand_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idx >= LOW) && (idx <= TOP));
  // R10: one step down per edge
  p_rand_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !at_low |=> idx == IDX_W'($past(idx) - 1'b1));
  // R10: wrap from the low bound to the top
  p_rand_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    at_low |=> idx == TOP);
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_slot,
  input  tlb_entry_t        wr_data,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_any,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic              lk_nc,
  output logic              lk_dirty,
  output logic              lk_valid,
  input  logic [VPN_W-1:0]  pr_vpn,
  output logic              pr_any,
  output logic [IDX_W-1:0]  pr_idx
);
  tlb_entry_t                 entries [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0]     lk_vec, pr_vec;
  logic [IDX_W-1:0]           lk_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) entries[i] <= '0;
    end else if (wr_en) begin
      entries[wr_slot] <= wr_data;
    end
  end

  // One comparator pair per entry
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign lk_vec[g] = tag_match(entries[g], lk_vpn, lk_asid);
    assign pr_vec[g] = tag_match(entries[g], pr_vpn, lk_asid);
  end

  // Lowest index wins
  always_comb begin
    lk_idx = '0;
    pr_idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (lk_vec[i]) lk_idx = IDX_W'(i);
      if (pr_vec[i]) pr_idx = IDX_W'(i);
    end
    lk_any   = |lk_vec;
    pr_any   = |pr_vec;
    lk_pfn   = entries[lk_idx].pfn;
    lk_nc    = entries[lk_idx].nc;
    lk_dirty = entries[lk_idx].dirty;
    lk_valid = entries[lk_idx].valid;
  end

  // R9: a written slot holds the written value one edge later
  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> entries[$past(wr_slot)] == $past(wr_data));
  // R8: reported probe slot really matches
  p_probe_slot_matches_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pr_any |-> pr_vec[pr_idx]);
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int LOW_BOUND   = 8,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic [VA_W-1:0]   acc_va,
  input  logic              acc_store,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              wr_en,
  input  logic              wr_random,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_nc,
  input  logic              wr_dirty,
  input  logic              wr_valid,
  input  logic              wr_global,
  input  logic              probe_en,
  input  logic [VPN_W-1:0]  probe_vpn,
  output logic [PA_W-1:0]   pa,
  output logic              hit,
  output logic              miss,
  output logic              uncached,
  output logic              fault_invalid,
  output logic              fault_modify,
  output logic [IDX_W-1:0]  probe_idx,
  output logic              probe_fail
);
  localparam int KPA_W = VA_W - 3;

  logic             mapped, phys_uncached;
  logic [IDX_W-1:0] rand_idx, wr_slot;
  tlb_entry_t       wr_data;
  logic             lk_any, lk_nc, lk_dirty, lk_valid, pr_any;
  logic [PFN_W-1:0] lk_pfn;
  logic [IDX_W-1:0] pr_idx;

  tlb_seg_decode u_seg (
    .va_top        (acc_va[VA_W-1 -: 3]),
    .mapped        (mapped),
    .phys_uncached (phys_uncached)
  );

  tlb_rand_idx #(.NUM_ENTRIES(NUM_ENTRIES), .LOW_BOUND(LOW_BOUND)) u_rand (
    .clk   (clk),
    .rst_n (rst_n),
    .idx   (rand_idx)
  );

  assign wr_slot = wr_random ? rand_idx : wr_index;
  assign wr_data = '{vpn: wr_vpn, asid: wr_asid, pfn: wr_pfn, nc: wr_nc,
                     dirty: wr_dirty, valid: wr_valid, glob: wr_global};

  tlb_cam #(.NUM_ENTRIES(NUM_ENTRIES)) u_cam (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_slot  (wr_slot),
    .wr_data  (wr_data),
    .lk_vpn   (acc_va[VA_W-1:OFF_W]),
    .lk_asid  (cur_asid),
    .lk_any   (lk_any),
    .lk_pfn   (lk_pfn),
    .lk_nc    (lk_nc),
    .lk_dirty (lk_dirty),
    .lk_valid (lk_valid),
    .pr_vpn   (probe_vpn),
    .pr_any   (pr_any),
    .pr_idx   (pr_idx)
  );

  always_comb begin
    hit           = 1'b0;
    miss          = 1'b0;
    uncached      = 1'b0;
    fault_invalid = 1'b0;
    fault_modify  = 1'b0;
    pa            = '0;
    if (acc_en) begin
      if (!mapped) begin
        hit      = 1'b1;
        uncached = phys_uncached;
        pa       = {{(PA_W-KPA_W){1'b0}}, acc_va[KPA_W-1:0]};
      end else if (!lk_any) begin
        miss = 1'b1;
      end else if (!lk_valid) begin
        fault_invalid = 1'b1;
      end else begin
        hit          = 1'b1;
        uncached     = lk_nc;
        pa           = {lk_pfn, acc_va[OFF_W-1:0]};
        fault_modify = acc_store && !lk_dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      probe_idx  <= '0;
      probe_fail <= 1'b0;
    end else if (probe_en) begin
      probe_idx  <= pr_any ? pr_idx : '0;
      probe_fail <= !pr_any;
    end
  end

  // R4: outcome flags are mutually exclusive
  p_outcome_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, miss, fault_invalid}));
  // R7: modify fault only on a store that completed translation
  p_modify_on_store_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_modify |-> (hit && acc_store && mapped));
  // R5: kernel physical segments never miss or fault
  p_kphys_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !mapped) |-> (hit && !miss && !fault_invalid && !fault_modify));
  // R1: idle lookup port is quiet
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> !(hit || miss || fault_invalid || fault_modify || uncached));
  // R11: probe result holds between probes
  p_probe_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !probe_en |=> ($stable(probe_idx) && $stable(probe_fail)));
endmodule

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0;
  logic [31:0] acc_va = '0;
  logic        acc_store = 1'b0;
  logic [5:0]  cur_asid = '0;
  logic        wr_en = 1'b0, wr_random = 1'b0;
  logic [5:0]  wr_index = '0;
  logic [19:0] wr_vpn = '0;
  logic [5:0]  wr_asid = '0;
  logic [19:0] wr_pfn = '0;
  logic        wr_nc = 1'b0, wr_dirty = 1'b0, wr_valid = 1'b0, wr_global = 1'b0;
  logic        probe_en = 1'b0;
  logic [19:0] probe_vpn = '0;
  logic [31:0] pa;
  logic        hit, miss, uncached, fault_invalid, fault_modify;
  logic [5:0]  probe_idx;
  logic        probe_fail;

  int checks = 0;
  int fails  = 0;
  int ncyc   = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  always @(posedge clk) begin
    if (!rst_n) ncyc <= 0;
    else        ncyc <= ncyc + 1;
  end

  asid_tlb u_dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_va(acc_va),
    .acc_store(acc_store), .cur_asid(cur_asid), .wr_en(wr_en),
    .wr_random(wr_random), .wr_index(wr_index), .wr_vpn(wr_vpn),
    .wr_asid(wr_asid), .wr_pfn(wr_pfn), .wr_nc(wr_nc), .wr_dirty(wr_dirty),
    .wr_valid(wr_valid), .wr_global(wr_global), .probe_en(probe_en),
    .probe_vpn(probe_vpn), .pa(pa), .hit(hit), .miss(miss),
    .uncached(uncached), .fault_invalid(fault_invalid),
    .fault_modify(fault_modify), .probe_idx(probe_idx),
    .probe_fail(probe_fail)
  );

  // {va, asid, store, hit miss finv fmod unc, pa}
  localparam int NV = 13;
  localparam logic [75:0] VECS [NV] = '{
    {32'h00012ABC, 6'd5,  1'b0, 5'b10000, 32'hABCDEABC},
    {32'h00012ABC, 6'd7,  1'b0, 5'b10000, 32'h55555ABC},
    {32'h00012ABC, 6'd6,  1'b0, 5'b01000, 32'h00000000},
    {32'h00034F00, 6'd9,  1'b0, 5'b10001, 32'h11111F00},
    {32'h00034F00, 6'd9,  1'b1, 5'b10011, 32'h11111F00},
    {32'h00056010, 6'd33, 1'b0, 5'b10000, 32'h22222010},
    {32'h00078000, 6'd5,  1'b0, 5'b00100, 32'h00000000},
    {32'h80001234, 6'd12, 1'b0, 5'b10000, 32'h00001234},
    {32'hA0001234, 6'd12, 1'b1, 5'b10001, 32'h00001234},
    {32'hC0012008, 6'd5,  1'b0, 5'b10000, 32'h44444008},
    {32'hC0012008, 6'd4,  1'b0, 5'b01000, 32'h00000000},
    {32'h00012ABC, 6'd5,  1'b1, 5'b10000, 32'hABCDEABC},
    {32'h00099000, 6'd5,  1'b0, 5'b01000, 32'h00000000}
  };

  function automatic string vtag(input int i);
    case (i)
      1:       return "R3";
      2, 10:   return "R4";
      4, 11:   return "R7";
      5:       return "R3";
      6:       return "R6";
      7, 8:    return "R5";
      12:      return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic rnd, input logic [5:0] idx, input logic [19:0] vpn,
                    input logic [5:0] asid, input logic [19:0] pfn,
                    input logic nc, input logic d, input logic v, input logic g);
    wr_en = 1'b1; wr_random = rnd; wr_index = idx; wr_vpn = vpn; wr_asid = asid;
    wr_pfn = pfn; wr_nc = nc; wr_dirty = d; wr_valid = v; wr_global = g;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_random = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic [5:0] asid, input logic st);
    acc_en = 1'b1; acc_va = va; cur_asid = asid; acc_store = st;
    #2;
  endtask

  task automatic probe(input logic [19:0] vpn, input logic [5:0] asid);
    probe_en = 1'b1; probe_vpn = vpn; cur_asid = asid;
    @(posedge clk);
    @(negedge clk);
    probe_en = 1'b0;
    #2;
  endtask

  function automatic logic [5:0] rand_now();
    return 6'(63 - (ncyc % 56));
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0] slot;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    // R1 reset state
    chk("R1", "probe_idx", 64'(probe_idx), 64'd0);
    chk("R1", "probe_fail", 64'(probe_fail), 64'd0);
    chk("R1", "idle flags", 64'({hit, miss, fault_invalid, fault_modify, uncached}), 64'd0);
    chk("R1", "idle pa", 64'(pa), 64'd0);
    look(32'h00099000, 6'd5, 1'b0);
    chk("R1", "cleared entries miss", 64'({hit, miss}), 64'b01);
    acc_en = 1'b0;
    @(negedge clk);

    wr(1'b0, 6'd0, 20'h00012, 6'd5, 20'hABCDE, 0, 1, 1, 0);
    wr(1'b0, 6'd1, 20'h00034, 6'd9, 20'h11111, 1, 0, 1, 0);
    wr(1'b0, 6'd2, 20'h00056, 6'd0, 20'h22222, 0, 1, 1, 1);
    wr(1'b0, 6'd3, 20'h00078, 6'd5, 20'h33333, 0, 1, 0, 0);
    wr(1'b0, 6'd4, 20'hC0012, 6'd5, 20'h44444, 0, 1, 1, 0);
    wr(1'b0, 6'd5, 20'h00012, 6'd7, 20'h55555, 0, 1, 1, 0);

    for (int i = 0; i < NV; i++) begin
      look(VECS[i][75:44], VECS[i][43:38], VECS[i][37]);
      chk(vtag(i), $sformatf("vector %0d flags", i),
          64'({hit, miss, fault_invalid, fault_modify, uncached}), 64'(VECS[i][36:32]));
      chk(vtag(i), $sformatf("vector %0d pa", i), 64'(pa), 64'(VECS[i][31:0]));
      @(negedge clk);
    end
    acc_en = 1'b0;

    // R11 probes
    probe(20'h00034, 6'd9);
    chk("R11", "probe idx", 64'({probe_fail, probe_idx}), {57'd0, 1'b0, 6'd1});
    probe(20'h00056, 6'd40);
    chk("R11", "probe global idx", 64'({probe_fail, probe_idx}), {57'd0, 1'b0, 6'd2});
    probe(20'h00099, 6'd5);
    chk("R11", "probe fail", 64'({probe_fail, probe_idx}), {57'd0, 1'b1, 6'd0});
    repeat (3) @(negedge clk);
    #2;
    chk("R11", "probe hold", 64'({probe_fail, probe_idx}), {57'd0, 1'b1, 6'd0});

    // R8 priority: duplicate at slot 6
    wr(1'b0, 6'd6, 20'h00012, 6'd5, 20'h66666, 0, 1, 1, 0);
    look(32'h00012100, 6'd5, 1'b0);
    chk("R8", "lowest slot wins", 64'(pa), 64'h00000000ABCDE100);
    acc_en = 1'b0;
    @(negedge clk);
    probe(20'h00012, 6'd5);
    chk("R8", "probe lowest slot", 64'(probe_idx), 64'd0);

    // R9 overwrite slot 0
    wr(1'b0, 6'd0, 20'h00FFF, 6'd5, 20'h77777, 0, 1, 1, 0);
    look(32'h00012100, 6'd5, 1'b0);
    chk("R9", "old mapping replaced", 64'(pa), 64'h0000000066666100);
    look(32'h00FFF004, 6'd5, 1'b0);
    chk("R9", "new mapping", 64'(pa), 64'h0000000077777004);
    acc_en = 1'b0;
    @(negedge clk);

    // R10 random slots
    for (int k = 0; k < 4; k++) begin
      slot = rand_now();
      wr(1'b1, 6'd0, 20'h0AA00 + 20'(k), 6'd5, 20'h0BB00 + 20'(k), 0, 1, 1, 0);
      probe(20'h0AA00 + 20'(k), 6'd5);
      chk("R10", "random slot", 64'({probe_fail, probe_idx}), {57'd0, 1'b0, slot});
    end
    while ((ncyc % 56) != 55) @(negedge clk);
    wr(1'b1, 6'd0, 20'h0CC08, 6'd5, 20'h0DD08, 0, 1, 1, 0);
    wr(1'b1, 6'd0, 20'h0CC3F, 6'd5, 20'h0DD3F, 0, 1, 1, 0);
    probe(20'h0CC08, 6'd5);
    chk("R10", "slot at low bound", 64'(probe_idx), 64'd8);
    probe(20'h0CC3F, 6'd5);
    chk("R10", "slot after wrap", 64'(probe_idx), 64'd63);
    for (int k = 0; k < 60; k++)
      wr(1'b1, 6'd0, 20'h0E000 + 20'(k), 6'd5, 20'h0F000 + 20'(k), 0, 1, 1, 0);
    look(32'h00034F00, 6'd9, 1'b0);
    chk("R10", "low slot survives", 64'({hit, pa}), {31'd0, 1'b1, 32'h11111F00});
    look(32'h00056010, 6'd1, 1'b0);
    chk("R10", "low global survives", 64'({hit, pa}), {31'd0, 1'b1, 32'h22222010});
    acc_en = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule